// File: doc/BRIEF.md
# Bus access abort decoder

This block watches the request side of a processor bus and decides, for each access, whether it must be refused. A request carries an address, a flag saying whether it is an instruction fetch or a data access, a write flag and a valid strobe. Data accesses that are refused raise a one-cycle data abort in the cycle after the request. A refused instruction fetch is not reported at once. Its abort flag is stored with the fetched word and moves down a three-stage fetch/decode/execute pipeline. The abort is raised only if that word reaches execute. A pipeline flush drops every pending flag, so a speculative fetch just past a region edge does no harm.

The rules depend on the access type. Any access to a reserved or unassigned area is refused. This covers the holes in the map, external memory, the space between the two peripheral buses, and peripheral slots that hold no device. Instruction fetches are also refused from both peripheral buses and from the special-register window, even where a device exists. Data writes to flash are refused, but flash reads are allowed. Inside an assigned slot of the low-speed peripheral bus, only the low offset bits are decoded, so an undefined offset lands on a defined register instead of aborting. The block drives the aliased address on a separate output. All region bounds, the slot size, the decode width and the slot-assignment masks are parameters.

Top module: `bus_abort_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, both data_abort and prefetch_abort are low.
- R2: A valid data access (req_fetch=0) to an address outside flash, the special window, SRAM, boot ROM and both peripheral ranges sets data_abort high for exactly the one cycle after the request.
- R3: A valid data access inside a peripheral range aborts when its 16 KiB slot is unassigned and does not abort when the slot is assigned. The default map assigns low-speed slots 0 to 11 and 127, and high-speed slots 0 and 127.
- R4: For an address in an assigned low-speed peripheral slot, dec_addr equals req_addr with bits 13:12 cleared, so that 0xE000D000 reads as 0xE000C000. For every other address, dec_addr equals req_addr.
- R5: A valid data write anywhere in flash (0x00000000 to 0x0007FFFF) aborts, and a valid data read of flash does not.
- R6: A valid fetch is tagged bad when its address is in either peripheral range (assigned or not), in the special window 0x3FFF8000 to 0x3FFFFFFF, or in a reserved area. Fetches from flash, SRAM and boot ROM are clean.
- R7: prefetch_abort is high exactly while a tagged entry occupies the execute stage. A fetch enters the fetch stage at the clock edge of the request. Each edge with advance=1 moves fetch to decode and decode to execute. An edge with advance=1 and no fetch request empties the fetch stage.
- R8: An edge with flush=1 clears all three stages, including a fetch presented in that cycle, so prefetch_abort is low in the following cycle.
- R9: A data abort and an execute-stage prefetch abort in the same cycle both assert.
- R10: Without advance or flush, the decode and execute stages hold, so prefetch_abort keeps its value.
- R11: A request with req_valid=0 raises no data abort and places no tag in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = data write |
| req_addr | input | 32 | Request address |
| advance | input | 1 | Pipeline shifts one stage |
| flush | input | 1 | Pipeline discards all entries |
| data_abort | output | 1 | Data access refused (one cycle after the request) |
| prefetch_abort | output | 1 | Tagged instruction is in execute |
| dec_addr | output | 32 | Address after peripheral alias decoding |

## Verification
The hardest situation to create is a tagged fetch that reaches execute on the same edge as a refused data access. A second hard case is a tagged entry that is flushed one stage short of execute. Both need a fetch, then exact advance timing, then a matching data request. Directed sequences build each case step by step. A long random run, with a fixed seed and a region-weighted address picker, mixes fetches, advances and flushes so that tags pile up and collide many times. Every cycle is compared against a bench-side model of the pipeline.

// File: rtl/bus_abort_decoder.sv
module bus_abort_decoder #(
  parameter logic [31:0] FLASH_LO = 32'h0000_0000,
  parameter logic [31:0] FLASH_HI = 32'h0007_FFFF,
  parameter logic [31:0] SPEC_LO  = 32'h3FFF_8000,
  parameter logic [31:0] SPEC_HI  = 32'h3FFF_FFFF,
  parameter logic [31:0] SRAM_LO  = 32'h4000_0000,
  parameter logic [31:0] SRAM_HI  = 32'h4000_7FFF,
  parameter logic [31:0] BOOT_LO  = 32'h7FFF_E000,
  parameter logic [31:0] BOOT_HI  = 32'h7FFF_FFFF,
  parameter logic [31:0] APB_LO   = 32'hE000_0000,
  parameter logic [31:0] AHB_LO   = 32'hFFE0_0000,
  parameter int SLOT_BITS = 14,
  parameter int NSLOT     = 128,
  parameter int DEC_BITS  = 12,
  parameter logic [NSLOT-1:0] APB_MAP = 128'h8000_0000_0000_0000_0000_0000_0000_0FFF,
  parameter logic [NSLOT-1:0] AHB_MAP = 128'h8000_0000_0000_0000_0000_0000_0000_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_fetch,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic        advance,
  input  logic        flush,
  output logic        data_abort,
  output logic        prefetch_abort,
  output logic [31:0] dec_addr
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [31:0] SPAN_M1 = 32'((64'(NSLOT) << SLOT_BITS) - 64'd1);
  localparam logic [31:0] ALIAS_MASK = 32'((64'd1 << SLOT_BITS) - (64'd1 << DEC_BITS));

  function automatic logic in_rng(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] span);
    return (a - lo) <= span;
  endfunction

  logic in_flash, in_spec, in_sram, in_boot, in_apb, in_ahb, known;
  logic [31:0] apb_off, ahb_off;
  logic [SW-1:0] apb_slot, ahb_slot;
  logic apb_ok, ahb_ok, fetch_bad, data_bad;
  logic tag_f, tag_d, tag_e;

  assign in_flash = in_rng(req_addr, FLASH_LO, FLASH_HI - FLASH_LO);
  assign in_spec  = in_rng(req_addr, SPEC_LO, SPEC_HI - SPEC_LO);
  assign in_sram  = in_rng(req_addr, SRAM_LO, SRAM_HI - SRAM_LO);
  assign in_boot  = in_rng(req_addr, BOOT_LO, BOOT_HI - BOOT_LO);
  assign in_apb   = in_rng(req_addr, APB_LO, SPAN_M1);
  assign in_ahb   = in_rng(req_addr, AHB_LO, SPAN_M1);
  assign known    = in_flash | in_spec | in_sram | in_boot | in_apb | in_ahb;

  assign apb_off  = req_addr - APB_LO;
  assign ahb_off  = req_addr - AHB_LO;
  assign apb_slot = SW'(apb_off >> SLOT_BITS);
  assign ahb_slot = SW'(ahb_off >> SLOT_BITS);
  assign apb_ok   = in_apb & APB_MAP[apb_slot];
  assign ahb_ok   = in_ahb & AHB_MAP[ahb_slot];

  assign fetch_bad = !known | in_apb | in_ahb | in_spec;
  assign data_bad  = !known | (in_apb & !apb_ok) | (in_ahb & !ahb_ok) | (req_write & in_flash);
  assign dec_addr  = apb_ok ? (req_addr & ~ALIAS_MASK) : req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_abort <= 1'b0;
      tag_f <= 1'b0;
      tag_d <= 1'b0;
      tag_e <= 1'b0;
    end else begin
      data_abort <= req_valid && !req_fetch && data_bad;
      if (flush) begin
        tag_f <= 1'b0;
        tag_d <= 1'b0;
        tag_e <= 1'b0;
      end else begin
        if (advance) begin
          tag_e <= tag_d;
          tag_d <= tag_f;
        end
        if (req_valid && req_fetch) tag_f <= fetch_bad;
        else if (advance)           tag_f <= 1'b0;
      end
    end
  end

  assign prefetch_abort = tag_e;

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!data_abort && !prefetch_abort));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !data_abort);
  a_r5_flash_read_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fetch && !req_write && in_flash) |=> !data_abort);
  a_r3_assigned_slot_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fetch && (apb_ok || ahb_ok)) |=> !data_abort);
  a_r7_rise_needs_advance: assert property (@(posedge clk) disable iff (rst)
    $rose(prefetch_abort) |-> $past(advance));
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst) flush |=> !prefetch_abort);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !flush) |=> $stable(prefetch_abort));
endmodule

// File: tb/test_bus_abort_decoder.sv
`timescale 1ns/1ps
module test_bus_abort_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic advance = 1'b0, flush = 1'b0;
  logic data_abort, prefetch_abort;
  logic [31:0] dec_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit m_f, m_d, m_e, m_dabt;

  always #2.5 clk = ~clk;

  bus_abort_decoder i_bus_abort_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_write(req_write), .req_addr(req_addr), .advance(advance), .flush(flush),
    .data_abort(data_abort), .prefetch_abort(prefetch_abort), .dec_addr(dec_addr));

  function automatic bit rng(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a - lo) <= (hi - lo);
  endfunction
  function automatic bit is_apb(logic [31:0] a); return rng(a, 32'hE000_0000, 32'hE01F_FFFF); endfunction
  function automatic bit is_ahb(logic [31:0] a); return rng(a, 32'hFFE0_0000, 32'hFFFF_FFFF); endfunction
  function automatic bit is_flash(logic [31:0] a); return rng(a, 32'h0, 32'h0007_FFFF); endfunction
  function automatic bit is_spec(logic [31:0] a); return rng(a, 32'h3FFF_8000, 32'h3FFF_FFFF); endfunction
  function automatic bit is_mem(logic [31:0] a);
    return is_flash(a) || rng(a, 32'h4000_0000, 32'h4000_7FFF) || rng(a, 32'h7FFF_E000, 32'h7FFF_FFFF);
  endfunction
  function automatic bit apb_assigned(logic [31:0] a);
    int s = int'((a - 32'hE000_0000) >> 14);
    return is_apb(a) && (s < 12 || s == 127);
  endfunction
  function automatic bit ahb_assigned(logic [31:0] a);
    int s = int'((a - 32'hFFE0_0000) >> 14);
    return is_ahb(a) && (s == 0 || s == 127);
  endfunction
  function automatic bit exp_fetch_bad(logic [31:0] a);
    return !is_mem(a);
  endfunction
  function automatic bit exp_data_bad(logic [31:0] a, bit w);
    if (is_flash(a)) return w;
    if (is_mem(a) || is_spec(a)) return 1'b0;
    if (is_apb(a)) return !apb_assigned(a);
    if (is_ahb(a)) return !ahb_assigned(a);
    return 1'b1;
  endfunction
  function automatic logic [31:0] exp_dec(logic [31:0] a);
    return apb_assigned(a) ? (a & ~32'h0000_3000) : a;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit fch, bit w, logic [31:0] a, bit adv, bit fl, string tag);
    bit nf, nd, ne;
    req_valid = v; req_fetch = fch; req_write = w; req_addr = a; advance = adv; flush = fl;
    #1;
    check(dec_addr == exp_dec(a), tag, "dec_addr", dec_addr, exp_dec(a));
    @(posedge clk);
    m_dabt = v && !fch && exp_data_bad(a, w);
    nf = m_f; nd = m_d; ne = m_e;
    if (fl) begin nf = 0; nd = 0; ne = 0; end
    else begin
      if (adv) begin ne = m_d; nd = m_f; nf = 0; end
      if (v && fch) nf = exp_fetch_bad(a);
    end
    m_f = nf; m_d = nd; m_e = ne;
    #1;
    check(data_abort == m_dabt, tag, "data_abort", 32'(data_abort), 32'(m_dabt));
    check(prefetch_abort == m_e, tag, "prefetch_abort", 32'(prefetch_abort), 32'(m_e));
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 9))
      0: return 32'h0000_0000 + ($urandom % 32'h0008_0000);
      1: return 32'h0008_0000 + ($urandom % 32'h3FF7_8000);
      2: return 32'h3FFF_8000 + ($urandom % 32'h0000_8000);
      3: return 32'h4000_0000 + ($urandom % 32'h0000_8000);
      4: return 32'h4000_8000 + ($urandom % 32'h3FFF_6000);
      5: return 32'h7FFF_E000 + ($urandom % 32'h0000_2000);
      6: return 32'h8000_0000 + ($urandom % 32'h6000_0000);
      7: return 32'hE000_0000 + ($urandom % 32'h0020_0000);
      8: return 32'hE020_0000 + ($urandom % 32'h1FC0_0000);
      default: return 32'hFFE0_0000 + ($urandom % 32'h0020_0000);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    m_f = 0; m_d = 0; m_e = 0; m_dabt = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!data_abort && !prefetch_abort, "R1", "outputs in reset", {data_abort, prefetch_abort}, 0);
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 32'h0, 0, 0, "R1");
    // R2 reserved regions
    step(1, 0, 0, 32'h0010_0000, 0, 0, "R2");
    step(1, 0, 1, 32'h9000_0000, 0, 0, "R2");
    step(1, 0, 0, 32'hE030_0000, 0, 0, "R2");
    step(1, 0, 0, 32'h5000_0000, 0, 0, "R2");
    step(1, 0, 0, 32'h4000_0000, 0, 0, "R2");
    // R3 slot assignment
    step(1, 0, 0, 32'hE00A_0000, 0, 0, "R3");
    step(1, 0, 1, 32'hE000_C004, 0, 0, "R3");
    step(1, 0, 0, 32'hFFE0_4000, 0, 0, "R3");
    step(1, 0, 0, 32'hFFFF_F000, 0, 0, "R3");
    // R4 aliasing
    step(1, 0, 0, 32'hE000_D000, 0, 0, "R4");
    step(1, 0, 0, 32'hE01F_F123, 0, 0, "R4");
    step(1, 0, 0, 32'hFFE0_3123, 0, 0, "R4");
    // R5 flash writes
    step(1, 0, 1, 32'h0000_1000, 0, 0, "R5");
    step(1, 0, 0, 32'h0000_1000, 0, 0, "R5");
    step(1, 0, 1, 32'h0007_FFFC, 0, 0, "R5");
    // R6 and R7 tagged fetch walks to execute
    step(1, 1, 0, 32'hE000_C000, 0, 0, "R6");
    step(0, 0, 0, 32'h0, 1, 0, "R7");
    step(0, 0, 0, 32'h0, 1, 0, "R7");
    step(0, 0, 0, 32'h0, 1, 0, "R7");
    step(1, 1, 0, 32'h0000_0100, 1, 0, "R6");
    step(1, 1, 0, 32'h7FFF_E000, 1, 0, "R6");
    step(1, 1, 0, 32'h4000_0010, 1, 0, "R6");
    // R8 flush before execute
    step(1, 1, 0, 32'h3FFF_8000, 1, 0, "R8");
    step(0, 0, 0, 32'h0, 1, 0, "R8");
    step(1, 1, 0, 32'hFFFF_F000, 0, 1, "R8");
    step(0, 0, 0, 32'h0, 1, 0, "R8");
    step(0, 0, 0, 32'h0, 1, 0, "R8");
    // R9 coincident aborts
    step(1, 1, 0, 32'h8000_0000, 1, 0, "R9");
    step(0, 0, 0, 32'h0, 1, 0, "R9");
    step(1, 0, 0, 32'h0010_0000, 1, 0, "R9");
    // R10 hold without advance
    step(0, 0, 0, 32'h0, 0, 0, "R10");
    step(1, 0, 0, 32'h4000_0000, 0, 0, "R10");
    step(0, 0, 0, 32'h0, 1, 0, "R10");
    // R11 invalid requests
    step(0, 0, 1, 32'h0000_1000, 0, 0, "R11");
    step(0, 1, 0, 32'hE000_0000, 1, 0, "R11");
    step(0, 0, 0, 32'h0, 1, 0, "R11");
    step(0, 0, 0, 32'h0, 1, 0, "R11");
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 8) != 0;
      bit fch = $urandom % 2;
      bit w = $urandom % 2;
      bit adv = ($urandom % 3) != 0;
      bit fl = ($urandom % 16) == 0;
      step(v, fch, w, pick(), adv, fl, "random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule